// File: doc/BRIEF.md
# Smartcard Character Transceiver with Error-Signal Retry

This block moves 8-bit characters in both directions over one open-drain I/O line shared with a smartcard. The line idles high through an external pull-up. The block pulls the line low by raising `io_oe_o` and reads the line back on `io_i`. A character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. One or two guard ETUs follow. One ETU is `ETU_CYCLES` clock cycles. The receiver samples each bit once, at the middle of its ETU.

A receiver that finds bad parity can pull the line low for the whole ETU after the parity bit. This tells the sender to repeat the character. The transmitter reads the line in the middle of the first guard ETU. If it sees that low level, it resends the byte until its retry budget runs out, and then it reports a transmit error. Each direction has its own retry enable and a 3-bit count field that holds the number of retries minus one. The count field must be changed only while its enable is low. The link is half-duplex: only one of the transmitter and the receiver is active at any time.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset `io_oe_o`, `rx_valid_o`, `rx_err_o`, `tx_done_o` and `tx_err_o` are all 0, so the line is released.
- R2: A pulse on `tx_valid_i`, taken while the block is idle and the line is high, sends a frame of `ETU_CYCLES` clocks per bit. The frame is a low start bit, `tx_data_i` bit 0 first, then a parity bit equal to the XOR of the data bits. `io_oe_o`=1 means the line is driven low.
- R3: With `two_stop_i`=0 the transmitter releases the line for one guard ETU, and `tx_done_o` pulses 11 ETUs after the start bit begins. With `two_stop_i`=1 there are two guard ETUs and the pulse comes 12 ETUs after the start bit begins.
- R4: The transmitter samples the line in the middle of the first guard ETU; a low level there is an error signal. With `tx_rty_en_i`=1 and count field k, it resends the byte after each error signal, up to k+1 times in all. If the last of those attempts is also refused, `tx_err_o` pulses together with `tx_done_o`.
- R5: With `tx_rty_en_i`=0, an error signal ends the character at once: `tx_err_o` pulses with `tx_done_o` and the byte is not sent again.
- R6: The receiver samples the middle of each bit. When parity is even, `rx_valid_o` pulses for one cycle at the end of the parity ETU, with the byte on `rx_data_o`. `rx_valid_o` and `rx_err_o` are never high together.
- R7: With `rx_rty_en_i`=1 and count field k, a parity error makes the receiver pull the line low for the whole ETU after the parity bit, with no `rx_valid_o`. It does this for at most k+1 bad characters in a row. The next bad character raises `rx_err_o` instead, with no error signal. A good character resets this run count.
- R8: With `rx_rty_en_i`=0, a parity error raises `rx_err_o` and the receiver never drives the line.
- R9: `tx_valid_i` is ignored while a character is in progress. No second frame follows the current one.
- R10: While the transmitter is active, the receiver ignores the line and raises neither `rx_valid_o` nor `rx_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_i | input | 1 | Level of the shared I/O line |
| io_oe_o | output | 1 | 1 pulls the I/O line low |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | Single-cycle request to send `tx_data_i` |
| two_stop_i | input | 1 | 1: two guard ETUs, 0: one |
| tx_rty_en_i | input | 1 | Transmit retry enable |
| tx_rty_cnt_i | input | CNT_W | Transmit retries minus one |
| rx_rty_en_i | input | 1 | Receive error-signal enable |
| rx_rty_cnt_i | input | CNT_W | Receive error signals allowed minus one |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | Pulse: good byte received |
| tx_done_o | output | 1 | Pulse: transmit character finished |
| tx_err_o | output | 1 | Pulse with `tx_done_o`: retries exhausted |
| rx_err_o | output | 1 | Pulse: parity error not signalled |

## Verification
A wrong bit index or a wrong ETU counter shows up at once as wrong data or wrong parity. The card model decodes these in the middle of every ETU of the same frame. An error in the guard-period sampling or in the retry counter changes the number of start bits seen on the line. It also decides whether `tx_err_o` comes with `tx_done_o`. Both are visible within two ETUs after the last expected attempt. On the receive side, a run count that is not cleared or not bounded changes whether the next bad character is answered with a low guard ETU or with `rx_err_o`. That difference is seen in the ETU right after the parity bit.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_SIGNAL} rx_state_e;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mid_o,
  output logic end_o
);
  localparam int CW   = $clog2(ETU_CYCLES);
  localparam int HALF = ETU_CYCLES / 2 - 1;

  logic [CW-1:0] cnt_q;

  assign mid_o = run_i && (cnt_q == CW'(HALF));
  assign end_o = run_i && (cnt_q == CW'(ETU_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              two_stop_i,
  input  logic              rty_en_i,
  input  logic [CNT_W-1:0]  rty_cnt_i,
  input  logic              io_i,
  output logic              busy_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int BW = $clog2(DATA_W + 4);
  localparam logic [BW-1:0] LAST_DATA = BW'(DATA_W);
  localparam logic [BW-1:0] PAR_IDX   = BW'(DATA_W + 1);
  localparam logic [BW-1:0] GUARD_IDX = BW'(DATA_W + 2);

  tx_state_e         state_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] data_q, sh_q;
  logic              par_q, err_seen_q;
  logic [CNT_W:0]    tries_q, limit;
  logic              etu_mid, etu_end, tx_bit, last_guard;

  sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != TX_IDLE),
    .mid_o (etu_mid),
    .end_o (etu_end)
  );

  assign limit  = {1'b0, rty_cnt_i} + 1'b1;
  assign busy_o = (state_q != TX_IDLE);
  assign last_guard = two_stop_i ? (bit_q == GUARD_IDX + 1'b1) : (bit_q == GUARD_IDX);

  always_comb begin
    tx_bit = 1'b1;
    if (state_q == TX_SEND) begin
      if (bit_q == '0)              tx_bit = 1'b0;
      else if (bit_q <= LAST_DATA)  tx_bit = sh_q[0];
      else                          tx_bit = par_q;
    end
  end
  assign oe_o = (state_q == TX_SEND) && !tx_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      bit_q      <= '0;
      data_q     <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      err_seen_q <= 1'b0;
      tries_q    <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          data_q  <= data_i;
          sh_q    <= data_i;
          par_q   <= ^data_i;
          bit_q   <= '0;
          tries_q <= '0;
          state_q <= TX_SEND;
        end
        TX_SEND: if (etu_end) begin
          if (bit_q != '0 && bit_q <= LAST_DATA) sh_q <= sh_q >> 1;
          if (bit_q == PAR_IDX) begin
            err_seen_q <= 1'b0;
            state_q    <= TX_GUARD;
          end
          bit_q <= bit_q + 1'b1;
        end
        TX_GUARD: begin
          if (etu_mid && bit_q == GUARD_IDX) err_seen_q <= !io_i;
          if (etu_end) begin
            if (!last_guard) begin
              bit_q <= bit_q + 1'b1;
            end else if (err_seen_q && rty_en_i && tries_q < limit) begin
              tries_q <= tries_q + 1'b1;
              sh_q    <= data_q;
              bit_q   <= '0;
              state_q <= TX_SEND;
            end else begin
              done_o  <= 1'b1;
              err_o   <= err_seen_q;
              state_q <= TX_IDLE;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  AST_TX_TRIES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> tries_q <= limit);  // R4
  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> oe_o);  // R2
  AST_TX_GUARD_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_GUARD) |-> !oe_o);  // R3
endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              io_i,
  input  logic              rty_en_i,
  input  logic [CNT_W-1:0]  rty_cnt_i,
  output logic              busy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int BW = $clog2(DATA_W + 4);
  localparam logic [BW-1:0] LAST_DATA = BW'(DATA_W);
  localparam logic [BW-1:0] PAR_IDX   = BW'(DATA_W + 1);

  rx_state_e         state_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_ok_q;
  logic [CNT_W:0]    errs_q, limit;
  logic              etu_mid, etu_end;

  sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != RX_IDLE),
    .mid_o (etu_mid),
    .end_o (etu_end)
  );

  assign limit  = {1'b0, rty_cnt_i} + 1'b1;
  assign busy_o = (state_q != RX_IDLE);
  assign oe_o   = (state_q == RX_SIGNAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      par_ok_q <= 1'b0;
      errs_q   <= '0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (en_i && !io_i) begin
          bit_q   <= '0;
          state_q <= RX_DATA;
        end
        RX_DATA: begin
          if (etu_mid) begin
            if (bit_q == '0 && io_i)          state_q  <= RX_IDLE;  // glitch, not a start bit
            else if (bit_q != '0 && bit_q <= LAST_DATA)
                                              sh_q     <= {io_i, sh_q[DATA_W-1:1]};
            else if (bit_q == PAR_IDX)        par_ok_q <= !(^sh_q ^ io_i);
          end
          if (etu_end) begin
            if (bit_q != PAR_IDX) begin
              bit_q <= bit_q + 1'b1;
            end else if (par_ok_q) begin
              data_o  <= sh_q;
              valid_o <= 1'b1;
              errs_q  <= '0;
              state_q <= RX_IDLE;
            end else if (rty_en_i && errs_q < limit) begin
              errs_q  <= errs_q + 1'b1;
              state_q <= RX_SIGNAL;
            end else begin
              data_o  <= sh_q;
              err_o   <= 1'b1;
              errs_q  <= '0;
              state_q <= RX_IDLE;
            end
          end
        end
        RX_SIGNAL: if (etu_end) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_RX_SIGNAL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> rty_en_i);  // R8
  AST_RX_ERRS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rty_en_i |-> errs_q <= limit);  // R7
  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R6
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
  parameter int ETU_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_i,
  output logic              io_oe_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              two_stop_i,
  input  logic              tx_rty_en_i,
  input  logic [CNT_W-1:0]  tx_rty_cnt_i,
  input  logic              rx_rty_en_i,
  input  logic [CNT_W-1:0]  rx_rty_cnt_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_done_o,
  output logic              tx_err_o,
  output logic              rx_err_o
);
  logic tx_busy, rx_busy, tx_oe, rx_oe, tx_start;

  // new frame only on a quiet, idle line
  assign tx_start = tx_valid_i && !tx_busy && !rx_busy && io_i;
  assign io_oe_o  = tx_oe | rx_oe;

  sc_tx_engine #(.ETU_CYCLES(ETU_CYCLES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tx_start),
    .data_i    (tx_data_i),
    .two_stop_i(two_stop_i),
    .rty_en_i  (tx_rty_en_i),
    .rty_cnt_i (tx_rty_cnt_i),
    .io_i      (io_i),
    .busy_o    (tx_busy),
    .oe_o      (tx_oe),
    .done_o    (tx_done_o),
    .err_o     (tx_err_o)
  );

  sc_rx_engine #(.ETU_CYCLES(ETU_CYCLES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!tx_busy),
    .io_i     (io_i),
    .rty_en_i (rx_rty_en_i),
    .rty_cnt_i(rx_rty_cnt_i),
    .busy_o   (rx_busy),
    .oe_o     (rx_oe),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o),
    .err_o    (rx_err_o)
  );

  AST_HALF_DUPLEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_busy && rx_busy));  // R10
  AST_RX_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o));  // R6
  AST_TX_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> tx_done_o);  // R4
  AST_TX_RTY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rty_en_i && $past(tx_rty_en_i)) |-> $stable(tx_rty_cnt_i));  // R4
  AST_RX_RTY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rty_en_i && $past(rx_rty_en_i)) |-> $stable(rx_rty_cnt_i));  // R7
endmodule

// File: tb/tb_sc_char_xcvr.sv
module tb_sc_char_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int E = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       io_oe, card_low = 1'b0, line;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_valid = 1'b0, two_stop = 1'b1;
  logic       tx_rty_en = 1'b0, rx_rty_en = 1'b0;
  logic [2:0] tx_rty_cnt = '0, rx_rty_cnt = '0;
  logic       rx_valid, tx_done, tx_err, rx_err;

  int n_chk = 0, n_fail = 0;
  int n_done = 0, n_txerr = 0, n_rxv = 0, n_rxerr = 0;
  logic [7:0] rx_last = '0;

  assign line = !(io_oe | card_low);

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_char_xcvr #(.ETU_CYCLES(E), .DATA_W(8), .CNT_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .io_i(line), .io_oe_o(io_oe),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .two_stop_i(two_stop),
    .tx_rty_en_i(tx_rty_en), .tx_rty_cnt_i(tx_rty_cnt),
    .rx_rty_en_i(rx_rty_en), .rx_rty_cnt_i(rx_rty_cnt),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_done_o(tx_done), .tx_err_o(tx_err), .rx_err_o(rx_err)
  );

  always @(negedge clk) begin
    if (tx_done)  n_done++;
    if (tx_err)   n_txerr++;
    if (rx_err)   n_rxerr++;
    if (rx_valid) begin n_rxv++; rx_last = rx_data; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tx_rty(input bit en, input int cnt);
    @(negedge clk) tx_rty_en = 1'b0;
    @(negedge clk) begin tx_rty_cnt = 3'(cnt); tx_rty_en = en; end
  endtask

  task automatic set_rx_rty(input bit en, input int cnt);
    @(negedge clk) rx_rty_en = 1'b0;
    @(negedge clk) begin rx_rty_cnt = 3'(cnt); rx_rty_en = en; end
  endtask

  task automatic pulse_tx(input logic [7:0] d);
    @(negedge clk) begin tx_data = d; tx_valid = 1'b1; end
    @(negedge clk) tx_valid = 1'b0;
  endtask

  // card side receiving one frame; optionally answers with an error signal
  task automatic card_rx(input bit sig, output logic [7:0] d, output bit par_ok);
    logic p;
    @(negedge clk);
    while (line) @(negedge clk);
    repeat (E / 2) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      repeat (E) @(negedge clk);
      d[b] = line;
    end
    repeat (E) @(negedge clk);
    p = line;
    par_ok = ((^d) ^ p) == 1'b0;
    repeat (E / 2) @(negedge clk);
    card_low = sig;
    repeat (E) @(negedge clk);
    card_low = 1'b0;
  endtask

  // card side sending one frame; reports whether the DUT signalled an error
  task automatic card_tx(input logic [7:0] d, input bit bad_par, output bit sig);
    @(negedge clk) card_low = 1'b1;
    repeat (E) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      card_low = !d[b];
      repeat (E) @(negedge clk);
    end
    card_low = !((^d) ^ bad_par);
    repeat (E) @(negedge clk);
    card_low = 1'b0;
    repeat (E / 2) @(negedge clk);
    sig = !line;
    repeat (E / 2 + E) @(negedge clk);
  endtask

  task automatic quiet_window(input string req);
    int lows = 0;
    repeat (3 * E) begin
      @(negedge clk);
      if (!line) lows++;
    end
    chk(req, lows, 0);
  endtask

  task automatic t_reset;
    chk("R1 io_oe", int'(io_oe), 0);
    chk("R1 pulses", n_done + n_txerr + n_rxv + n_rxerr, 0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] d; bit ok;
    logic [7:0] pats [2] = '{8'hA5, 8'h6E};
    two_stop = 1'b1;
    set_tx_rty(1'b0, 0);
    foreach (pats[i]) begin
      int d0 = n_done, e0 = n_txerr, v0 = n_rxv + n_rxerr;
      fork
        pulse_tx(pats[i]);
        card_rx(1'b0, d, ok);
      join
      quiet_window("R2 single frame");
      chk("R2 data", int'(d), int'(pats[i]));
      chk("R2 parity", int'(ok), 1);
      chk("R2 done", n_done - d0, 1);
      chk("R2 no err", n_txerr - e0, 0);
      chk("R10 rx silent during tx", n_rxv + n_rxerr - v0, 0);
    end
  endtask

  task automatic t_stop_len(input bit two, input int exp);
    int n = 0;
    two_stop = two;
    pulse_tx(8'h5C);
    chk("R3 start asserted", int'(io_oe), 1);
    while (!tx_done && n < 20 * E) begin
      @(negedge clk);
      n++;
    end
    chk(two ? "R3 two stop length" : "R3 one stop length", n, exp);
    repeat (2 * E) @(negedge clk);
  endtask

  task automatic t_tx_retry(input bit two, input bit en, input int cnt,
                            input int n_bad, input int exp_att, input int exp_err,
                            input string req);
    logic [7:0] d; bit ok;
    int d0 = n_done, e0 = n_txerr;
    two_stop = two;
    set_tx_rty(en, cnt);
    pulse_tx(8'hC3);
    for (int a = 0; a < exp_att; a++) begin
      card_rx(a < n_bad, d, ok);
      chk({req, " attempt data"}, int'(d), 8'hC3);
      chk({req, " attempt parity"}, int'(ok), 1);
    end
    quiet_window({req, " no extra attempt"});
    chk({req, " done"}, n_done - d0, 1);
    chk({req, " tx_err"}, n_txerr - e0, exp_err);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d; bit ok;
    int d0 = n_done;
    two_stop = 1'b1;
    set_tx_rty(1'b0, 0);
    fork
      begin pulse_tx(8'h3C); repeat (3 * E) @(negedge clk); pulse_tx(8'hFF); end
      card_rx(1'b0, d, ok);
    join
    quiet_window("R9 no second frame");
    chk("R9 data kept", int'(d), 8'h3C);
    chk("R9 one done", n_done - d0, 1);
  endtask

  task automatic rx_one(input logic [7:0] d, input bit bad, input int exp_sig,
                        input int exp_v, input int exp_e, input string req);
    bit sig;
    int v0 = n_rxv, e0 = n_rxerr;
    card_tx(d, bad, sig);
    chk({req, " error signal"}, int'(sig), exp_sig);
    chk({req, " rx_valid"}, n_rxv - v0, exp_v);
    chk({req, " rx_err"}, n_rxerr - e0, exp_e);
    if (exp_v == 1) chk({req, " rx_data"}, int'(rx_last), int'(d));
  endtask

  task automatic t_rx;
    set_rx_rty(1'b1, 0);
    rx_one(8'h5A, 1'b0, 0, 1, 0, "R6 good");
    rx_one(8'h81, 1'b0, 0, 1, 0, "R6 good2");
    rx_one(8'h33, 1'b1, 1, 0, 0, "R7 first bad");
    rx_one(8'h33, 1'b1, 0, 0, 1, "R7 limit hit");
    rx_one(8'h33, 1'b1, 1, 0, 0, "R7 run restarts");
    rx_one(8'h33, 1'b0, 0, 1, 0, "R7 good after bad");
    rx_one(8'h47, 1'b1, 1, 0, 0, "R7 count cleared by good");
    rx_one(8'h47, 1'b0, 0, 1, 0, "R7 recover");
    set_rx_rty(1'b1, 1);
    rx_one(8'h99, 1'b1, 1, 0, 0, "R7 k1 bad1");
    rx_one(8'h99, 1'b1, 1, 0, 0, "R7 k1 bad2");
    rx_one(8'h99, 1'b1, 0, 0, 1, "R7 k1 bad3");
    set_rx_rty(1'b0, 0);
    rx_one(8'h0F, 1'b1, 0, 0, 1, "R8 disabled");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_stop_len(1'b0, 11 * E);
    t_stop_len(1'b1, 12 * E);
    t_tx_retry(1'b1, 1'b1, 1, 3, 3, 1, "R4 exhaust two-stop");
    t_tx_retry(1'b0, 1'b1, 1, 3, 3, 1, "R4 exhaust one-stop");
    t_tx_retry(1'b1, 1'b1, 1, 1, 2, 0, "R4 recover");
    t_tx_retry(1'b1, 1'b0, 0, 1, 1, 1, "R5 disabled");
    t_busy_ignore();
    t_rx();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule